// File: doc/BRIEF.md
# GPIO Controller with Edge-Captured Interrupts

This block is a general-purpose I/O controller serving a configurable number of lines (32 by default) behind a simple word-wide register bus. Software chooses per line whether the pad is driven or sampled, and whether a driven line is push-pull or drives low only (open-drain style). A data register holds the value driven on output lines. A read of that register returns this driven value for output lines and the synchronized pad level for input lines.

Every pad passes through a two-flop synchronizer. An edge detector then compares each synchronized sample with the one from the cycle before. Detected edges set a sticky per-line event bit, and software clears it by writing a one to that bit. Each line can record either falling edges only or both edges. A single interrupt output is high while any line has both its event bit and its mask bit set.

The bus has no wait states. A write takes effect at the clock edge where `bus_req` and `bus_wr` are both high. `bus_rdata` is a combinational function of `bus_addr` and the current state, so a read never stalls and needs no ready signal.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads 0, `pad_oe` is all zero and `irq_out` is low.
- R2: Word-aligned byte offsets select the registers: 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask, 0x14 edge mode. Pad port bit n is line n, and line n maps to register bit 31−n in every register.
- R3: A direction bit of 1 makes the line an output: `pad_oe` is high and `pad_out` equals the data bit when its open-drain bit is 0. A direction bit of 0 keeps `pad_oe` low.
- R4: On an output line whose open-drain bit is 1, `pad_oe` is high only while the data bit is 0. `pad_out` still follows the data bit.
- R5: A data read returns the written data bit for output lines. For input lines it returns the pad level, visible at the second rising clock edge after the pad changes.
- R6: With an edge-mode bit of 0, both rising and falling pad edges set the line's event bit at the third rising clock edge after the pad change.
- R7: With an edge-mode bit of 1, only falling edges set the event bit, and rising edges leave it unchanged.
- R8: A write to the event register clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing 0xFFFFFFFF clears all events.
- R9: `irq_out` is the OR over lines of (event AND mask). Events are recorded whatever the mask is, and with the mask at 0 `irq_out` stays low.
- R10: An edge detected in the same cycle as a clearing write to that line leaves its event bit set.
- R11: Reads of undecoded offsets (0x18, 0x1C, or any address whose two low bits are nonzero) return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_in | input | 32 | Pad levels, bit n = line n |
| pad_out | output | 32 | Pad output values, bit n = line n |
| pad_oe | output | 32 | Pad drive enables, bit n = line n |
| irq_out | output | 1 | Combined interrupt |

## Verification
An edge capture and a write-one-to-clear of the same event bit can land on the same clock edge. The bench provokes this by changing a pad level two cycles before it issues the clearing write. The write then commits at the edge where the new edge is captured, and the bench expects the bit to stay set (R10). A plain clear with no edge present must empty the bit. The bench also sweeps all lines in turn, and for each line checks the bit-reversed event position, the interrupt, and that clearing other bits has no effect.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned IDX_W  = ADDR_W - 2;

  localparam logic [IDX_W-1:0] IDX_DIR  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_ODRN = 3'd1;
  localparam logic [IDX_W-1:0] IDX_DATA = 3'd2;
  localparam logic [IDX_W-1:0] IDX_EVT  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_MASK = 3'd4;
  localparam logic [IDX_W-1:0] IDX_EDGE = 3'd5;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_evt.sv
module gpio_edge_evt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] fall_only,
  input  logic [W-1:0] clr,
  output logic [W-1:0] evt_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] cap;

  // a changed sample is an edge; falling-only lines also need prev high
  assign cap = (smp ^ prev_q) & (~fall_only | prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= smp;
      evt_q  <= (evt_q & ~clr) | cap;
    end
  end

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~evt_q & $past(evt_q) & ~$past(clr)) == '0)); // R8
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |=> ((evt_q & $past(clr) & ~$past(cap)) == '0)); // R8
  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((evt_q & ~$past(evt_q)) & $past(fall_only) & $past(smp)) == '0)); // R7
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~evt_q & $past(cap)) == '0)); // R10
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] odrn,
  input  logic [W-1:0] dout,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar n = 0; n < W; n++) begin : g_line
    localparam int unsigned B = W - 1 - n;
    assign pad_out[n] = dout[B];
    assign pad_oe[n]  = dir[B] & ~(odrn[B] & dout[B]);

    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      odrn[B] |-> !(pad_oe[n] && pad_out[n])); // R4
    AST_IN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      !dir[B] |-> !pad_oe[n]); // R3
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NLINES      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  output logic              irq_out
);
  logic [NLINES-1:0] dir_q, odrn_q, dat_q, msk_q, edg_q;
  logic [NLINES-1:0] in_bus, smp, evt, clr;
  logic [IDX_W-1:0]  idx;
  logic              aligned, wr_en;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_en   = bus_req & bus_wr & aligned;

  // pad port bit n -> register bit NLINES-1-n
  for (genvar n = 0; n < NLINES; n++) begin : g_rev
    assign in_bus[NLINES-1-n] = pad_in[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      odrn_q <= '0;
      dat_q  <= '0;
      msk_q  <= '0;
      edg_q  <= '0;
    end else if (wr_en) begin
      case (idx)
        IDX_DIR:  dir_q  <= bus_wdata;
        IDX_ODRN: odrn_q <= bus_wdata;
        IDX_DATA: dat_q  <= bus_wdata;
        IDX_MASK: msk_q  <= bus_wdata;
        IDX_EDGE: edg_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign clr = (wr_en && idx == IDX_EVT) ? bus_wdata : '0;

  gpio_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(in_bus), .q(smp)
  );

  gpio_edge_evt #(.W(NLINES)) u_evt (
    .clk(clk), .rst_n(rst_n), .smp(smp), .fall_only(edg_q),
    .clr(clr), .evt_q(evt)
  );

  gpio_pad_drv #(.W(NLINES)) u_pad (
    .clk(clk), .rst_n(rst_n), .dir(dir_q), .odrn(odrn_q), .dout(dat_q),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (idx)
        IDX_DIR:  bus_rdata = dir_q;
        IDX_ODRN: bus_rdata = odrn_q;
        IDX_DATA: bus_rdata = (dir_q & dat_q) | (~dir_q & smp);
        IDX_EVT:  bus_rdata = evt;
        IDX_MASK: bus_rdata = msk_q;
        IDX_EDGE: bus_rdata = edg_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign irq_out = |(evt & msk_q);

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |-> !irq_out); // R9
  AST_IRQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (evt != '0)); // R9
  AST_UNDECODED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!aligned || idx > IDX_EDGE) |-> (bus_rdata == '0)); // R11
  AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && (!aligned || idx > IDX_EDGE)) |=>
      (dir_q == $past(dir_q) && dat_q == $past(dat_q) && msk_q == $past(msk_q))); // R11
endmodule

// File: tb/sim_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_edge_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pad_in = '0, pad_out, pad_oe;
  logic        irq_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  gpio_edge_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  localparam logic [4:0] A_DIR = 5'h00, A_ODR = 5'h04, A_DAT = 5'h08,
                         A_EVT = 5'h0C, A_MSK = 5'h10, A_EDG = 5'h14;

  function automatic logic [31:0] rev(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[31-i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #2;
    d = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pats [4];
    pats[0] = 32'hA5C3_0F81; pats[1] = 32'h0000_FFFF;
    pats[2] = 32'h8000_0001; pats[3] = 32'h3C69_96C3;

    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    rd(A_DIR, v); chk("R1 dir", v, 0);
    rd(A_ODR, v); chk("R1 odr", v, 0);
    rd(A_DAT, v); chk("R1 dat", v, 0);
    rd(A_EVT, v); chk("R1 evt", v, 0);
    rd(A_MSK, v); chk("R1 msk", v, 0);
    rd(A_EDG, v); chk("R1 edg", v, 0);
    chk("R1 oe", pad_oe, 0);
    chk("R1 irq", {31'd0, irq_out}, 0);

    // R6 R2 R8 R9: per-line sweep, both edges
    wr(A_MSK, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      pad_in = 32'd1 << n;
      step(3);
      rd(A_EVT, v); chk("R6 R2 rise evt", v, 32'd1 << (31 - n));
      chk("R9 irq set", {31'd0, irq_out}, 1);
      wr(A_EVT, ~(32'd1 << (31 - n)));
      rd(A_EVT, v); chk("R8 zero bits keep", v, 32'd1 << (31 - n));
      wr(A_EVT, 32'd1 << (31 - n));
      rd(A_EVT, v); chk("R8 one clears", v, 0);
      chk("R9 irq clear", {31'd0, irq_out}, 0);
      pad_in = '0;
      step(3);
      rd(A_EVT, v); chk("R6 fall evt", v, 32'd1 << (31 - n));
      wr(A_EVT, 32'hFFFF_FFFF);
      rd(A_EVT, v); chk("R8 clear all", v, 0);
    end

    // R7 falling-only, R9 mask zero
    wr(A_MSK, 32'd0);
    wr(A_EDG, 32'hFFFF_FFFF);
    for (int p = 0; p < 4; p++) begin
      pad_in = pats[p];
      step(3);
      rd(A_EVT, v); chk("R7 rise ignored", v, 0);
      pad_in = '0;
      step(3);
      rd(A_EVT, v); chk("R7 fall captured", v, rev(pats[p]));
      chk("R9 masked quiet", {31'd0, irq_out}, 0);
      wr(A_EVT, 32'hFFFF_FFFF);
    end

    // R6 R7 mixed per-line edge mode
    wr(A_MSK, 32'hFFFF_FFFF);
    for (int p = 0; p < 4; p++) begin
      wr(A_EDG, pats[(p + 1) % 4]);
      pad_in = pats[p];
      step(3);
      rd(A_EVT, v); chk("R7 mixed rise", v, rev(pats[p]) & ~pats[(p + 1) % 4]);
      pad_in = '0;
      step(3);
      rd(A_EVT, v); chk("R6 mixed fall", v, rev(pats[p]));
      chk("R9 irq any", {31'd0, irq_out}, {31'd0, pats[p] != 0});
      wr(A_EVT, 32'hFFFF_FFFF);
    end
    wr(A_EDG, 32'd0);

    // R10 edge coincident with clear
    pad_in = 32'd1 << 5;
    step(3);
    rd(A_EVT, v); chk("R10 pre", v, 32'd1 << 26);
    pad_in = '0;
    step(2);
    wr(A_EVT, 32'd1 << 26);
    rd(A_EVT, v); chk("R10 edge beats clear", v, 32'd1 << 26);
    wr(A_EVT, 32'd1 << 26);
    rd(A_EVT, v); chk("R10 plain clear", v, 0);

    // R3 R4 R5 pad control and readback
    wr(A_MSK, 32'd0);
    for (int p = 0; p < 4; p++) begin
      logic [31:0] d, o, q, eoe;
      d = pats[p]; o = pats[(p + 2) % 4]; q = pats[(p + 3) % 4] ^ 32'h5555_5555;
      wr(A_DIR, d); wr(A_ODR, o); wr(A_DAT, pats[(p + 1) % 4]);
      pad_in = q;
      eoe = rev(d & ~(o & pats[(p + 1) % 4]));
      chk("R3 R4 pad_oe", pad_oe, eoe);
      chk("R3 pad_out", pad_out, rev(pats[(p + 1) % 4]));
      step(2);
      rd(A_DAT, v); chk("R5 readback", v, (d & pats[(p + 1) % 4]) | (~d & rev(q)));
      rd(A_DIR, v); chk("R2 dir reg", v, d);
      rd(A_ODR, v); chk("R2 odr reg", v, o);
      pad_in = '0;
      step(3);
      wr(A_EVT, 32'hFFFF_FFFF);
    end
    // R5 sync latency: one edge is too early
    wr(A_DIR, 32'd0);
    pad_in = 32'hFFFF_FFFF;
    step(1);
    rd(A_DAT, v); chk("R5 not yet", v, 0);
    step(1);
    rd(A_DAT, v); chk("R5 after two", v, 32'hFFFF_FFFF);
    pad_in = '0;
    step(3);
    wr(A_EVT, 32'hFFFF_FFFF);

    // R11 undecoded offsets
    wr(A_DIR, 32'h1234_5678);
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h01, 32'hFFFF_FFFF);
    rd(5'h18, v); chk("R11 read 18", v, 0);
    rd(5'h1C, v); chk("R11 read 1C", v, 0);
    rd(5'h02, v); chk("R11 read misaligned", v, 0);
    rd(A_DIR, v); chk("R11 dir kept", v, 32'h1234_5678);
    rd(A_MSK, v); chk("R11 msk kept", v, 0);
    rd(A_DAT, v); chk("R11 dat kept", v, 32'h1234_5678 & pats[0]);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule